// File: doc/BRIEF.md
# Branch Target Landing-Pad Checker

This block watches the instruction retirement stream and keeps one flag bit that records whether the previous retired instruction was a guarded indirect transfer. While the flag is set, the next retired instruction must be one of three landing-pad classes. Any other class retires with an invalid-state usage fault, and that instruction's architectural effects are suppressed.

The decoder supplies one descriptor per retirement. The descriptor carries a class code, a bit saying the instruction writes the PC, the branch or base register number, a write-back bit and a valid strobe. The flag is set only by a narrow group of indirect branches and PC-loading loads. Some of these depend on whether the register is the link register (14) or the stack pointer (13), and on write-back.

An enforcement-enable input gates fault generation without freezing the flag. An exception-entry clear input zeroes the flag, so a fault handler starts unchecked.

Top module: `lpad_guard`

## Requirements
- R1: After reset, flag_o is 0 and fault_o, suppress_o and cause_o are all 0.
- R2: Class codes 1, 2 and 3 are landing pads. They never fault, and a retired pad leaves flag_o at 0 on the next cycle.
- R3: When valid_i, enable_i and the flag are all 1 and the class is not a pad, fault_o and suppress_o are 1 in that same cycle and cause_o is 2'b01 (invalid state). The faulting instruction does not update the flag, so the flag stays 1. In every other cycle fault_o and suppress_o are 0 and cause_o is 2'b00.
- R4: Class codes 4 and 5 (link-and-exchange branches) always set the flag when they retire without a fault.
- R5: Class codes 6 and 7 (exchange branches) set the flag unless reg_i equals 14.
- R6: Class codes 8 and 9 (register-offset and literal loads) set the flag when wr_pc_i is 1.
- R7: Class codes 10, 11 and 12 (immediate-offset load, increment-after multiple load, decrement-before multiple load) set the flag when wr_pc_i is 1 and either reg_i is not 13 or wback_i is 0.
- R8: Every other non-faulting retirement leaves flag_o at 0 on the next cycle. This covers class codes 0 and 13 to 15, plain PC writes, loads that do not meet R6 or R7, and exchange branches through register 14.
- R9: exc_clear_i forces flag_o to 0 on the next cycle and takes priority over any retirement in the same cycle.
- R10: With enable_i at 0, no fault is raised, and the flag still follows R2 and R4 to R8.
- R11: A cycle with valid_i at 0 raises no fault and leaves the flag unchanged, unless exc_clear_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Enforcement enable |
| exc_clear_i | input | 1 | Exception-entry flag clear |
| valid_i | input | 1 | Retirement strobe |
| cls_i | input | 4 | Instruction class code |
| wr_pc_i | input | 1 | Instruction writes PC |
| reg_i | input | REG_W | Branch or base register number |
| wback_i | input | 1 | Base write-back |
| flag_o | output | 1 | Current branch-target flag |
| fault_o | output | 1 | Usage-fault pulse |
| cause_o | output | 2 | Fault cause, 2'b01 = invalid state |
| suppress_o | output | 1 | Suppress the retiring instruction |

## Verification
The bench builds the block with its defaults: a 4-bit class code and a 4-bit register field. At that size every combination of class, register number, PC-write bit and write-back bit can be crossed with both starting flag values and both enable settings. That covers every set and clear rule, every special case for registers 13 and 14, and fault generation with enforcement on and off. Separate sequences cover idle cycles and an exception clear that coincides with a setting or faulting retirement.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER   = 4'd0,
    CLS_PAD_ID  = 4'd1,
    CLS_PAD_GW  = 4'd2,
    CLS_PAD_PA  = 4'd3,
    CLS_BRL_X   = 4'd4,
    CLS_BRL_XN  = 4'd5,
    CLS_BR_X    = 4'd6,
    CLS_BR_XN   = 4'd7,
    CLS_LD_REG  = 4'd8,
    CLS_LD_LIT  = 4'd9,
    CLS_LD_IMM  = 4'd10,
    CLS_LDM_INC = 4'd11,
    CLS_LDM_DEC = 4'd12,
    CLS_MOV_PC  = 4'd13,
    CLS_RSV14   = 4'd14,
    CLS_RSV15   = 4'd15
  } lpad_cls_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_INVST  = 2'b01
  } lpad_cause_e;
endpackage

// File: rtl/lpad_classify.sv
module lpad_classify
  import lpad_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int LR_NUM = 14,
  parameter int SP_NUM = 13
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic             wr_pc_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic             wback_i,
  output logic             is_pad_o,
  output logic             sets_o
);
  localparam logic [REG_W-1:0] LR_IDX = REG_W'(LR_NUM);
  localparam logic [REG_W-1:0] SP_IDX = REG_W'(SP_NUM);

  lpad_cls_e cls;
  logic      not_lr;
  logic      base_ok;

  assign cls     = lpad_cls_e'(cls_i);
  assign not_lr  = (reg_i != LR_IDX);
  // SP base only qualifies without write-back
  assign base_ok = (reg_i != SP_IDX) || !wback_i;

  always_comb begin
    is_pad_o = 1'b0;
    sets_o   = 1'b0;
    unique case (cls)
      CLS_PAD_ID, CLS_PAD_GW, CLS_PAD_PA: is_pad_o = 1'b1;
      CLS_BRL_X, CLS_BRL_XN:              sets_o   = 1'b1;
      CLS_BR_X, CLS_BR_XN:                sets_o   = not_lr;
      CLS_LD_REG, CLS_LD_LIT:             sets_o   = wr_pc_i;
      CLS_LD_IMM, CLS_LDM_INC,
      CLS_LDM_DEC:                        sets_o   = wr_pc_i && base_ok;
      default:                            sets_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpad_check.sv
module lpad_check
  import lpad_pkg::*;
(
  input  logic        valid_i,
  input  logic        enable_i,
  input  logic        flag_i,
  input  logic        is_pad_i,
  output logic        fault_o,
  output lpad_cause_e cause_o
);
  assign fault_o = valid_i && enable_i && flag_i && !is_pad_i;
  assign cause_o = fault_o ? CAUSE_INVST : CAUSE_NONE;
endmodule

// File: rtl/lpad_flag.sv
module lpad_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  logic fault_i,
  input  logic sets_i,
  output logic flag_o
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clear_i)                 flag_d = 1'b0;
    else if (valid_i && !fault_i) flag_d = sets_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
  import lpad_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int LR_NUM = 14,
  parameter int SP_NUM = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             exc_clear_i,
  input  logic             valid_i,
  input  logic [3:0]       cls_i,
  input  logic             wr_pc_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic             wback_i,
  output logic             flag_o,
  output logic             fault_o,
  output logic [1:0]       cause_o,
  output logic             suppress_o
);
  logic        is_pad, sets, fault, flag;
  lpad_cause_e cause;

  lpad_classify #(
    .REG_W (REG_W),
    .LR_NUM(LR_NUM),
    .SP_NUM(SP_NUM)
  ) u_cls (
    .cls_i   (cls_i),
    .wr_pc_i (wr_pc_i),
    .reg_i   (reg_i),
    .wback_i (wback_i),
    .is_pad_o(is_pad),
    .sets_o  (sets)
  );

  lpad_check u_chk_logic (
    .valid_i (valid_i),
    .enable_i(enable_i),
    .flag_i  (flag),
    .is_pad_i(is_pad),
    .fault_o (fault),
    .cause_o (cause)
  );

  lpad_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(exc_clear_i),
    .valid_i(valid_i),
    .fault_i(fault),
    .sets_i (sets),
    .flag_o (flag)
  );

  assign flag_o     = flag;
  assign fault_o    = fault;
  assign suppress_o = fault;
  assign cause_o    = cause;
endmodule

// File: rtl/lpad_guard_chk.sv
module lpad_guard_chk #(
  parameter int REG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             exc_clear_i,
  input logic             valid_i,
  input logic [3:0]       cls_i,
  input logic             wr_pc_i,
  input logic [REG_W-1:0] reg_i,
  input logic             wback_i,
  input logic             flag_o,
  input logic             fault_o,
  input logic [1:0]       cause_o,
  input logic             suppress_o
);
  logic pad_cls;
  assign pad_cls = (cls_i == 4'd1) || (cls_i == 4'd2) || (cls_i == 4'd3);

  AST_FAULT_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (flag_o && valid_i)); // R3
  AST_FAULT_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (suppress_o && cause_o == 2'b01)); // R3
  AST_FAULT_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !exc_clear_i) |=> flag_o); // R3
  AST_PAD_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pad_cls) |-> !fault_o); // R2
  AST_PAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pad_cls) |=> !flag_o); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_clear_i |=> !flag_o); // R9
  AST_ENF_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !fault_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !exc_clear_i) |=> $stable(flag_o)); // R11
  AST_IDLE_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !fault_o); // R11
  AST_BRL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fault_o && !exc_clear_i && (cls_i == 4'd4 || cls_i == 4'd5)) |=> flag_o); // R4
endmodule

bind lpad_guard lpad_guard_chk #(.REG_W(REG_W)) u_lpad_chk (.*);

// File: tb/tb_lpad_guard.sv
module tb_lpad_guard;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0;
  logic             exc_clear_i = 1'b0;
  logic             valid_i = 1'b0;
  logic [3:0]       cls_i = '0;
  logic             wr_pc_i = 1'b0;
  logic [REG_W-1:0] reg_i = '0;
  logic             wback_i = 1'b0;
  logic             flag_o, fault_o, suppress_o;
  logic [1:0]       cause_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lpad_guard #(.REG_W(REG_W)) dut (.*);

  function automatic bit exp_sets(int c, int r, bit wpc, bit wb);
    case (c)
      4, 5:       return 1'b1;
      6, 7:       return r != 14;
      8, 9:       return wpc;
      10, 11, 12: return wpc && (r != 13 || !wb);
      default:    return 1'b0;
    endcase
  endfunction

  function automatic string req_of(int c);
    case (c)
      1, 2, 3:    return "R2";
      4, 5:       return "R4";
      6, 7:       return "R5";
      8, 9:       return "R6";
      10, 11, 12: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle; returns after edge, with comb outputs checked before it.
  task automatic cyc(bit en, bit clr, bit v, int c, int r, bit wpc, bit wb,
                     bit exp_fault, bit do_chk, string req);
    @(negedge clk_i);
    enable_i = en; exc_clear_i = clr; valid_i = v; cls_i = 4'(c);
    reg_i = REG_W'(r); wr_pc_i = wpc; wback_i = wb;
    #1;
    if (do_chk) begin
      chk({req, "/R3 fault"}, fault_o, exp_fault);
      chk({req, "/R3 suppress"}, suppress_o, exp_fault);
      chk({req, "/R3 cause"}, cause_o, exp_fault ? 1 : 0);
    end
    @(posedge clk_i);
    #1;
    valid_i = 1'b0; exc_clear_i = 1'b0;
  endtask

  task automatic set_flag(bit want);
    cyc(1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "");
    if (want) cyc(1'b1, 1'b0, 1'b1, 4, 0, 1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/4);
    chk("R1 flag", flag_o, 0);
    chk("R1 fault", fault_o, 0);
    chk("R1 suppress", suppress_o, 0);
    chk("R1 cause", cause_o, 0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // Exhaustive sweep over descriptor, start flag and enable
    for (int f0 = 0; f0 < 2; f0++)
      for (int en = 0; en < 2; en++)
        for (int c = 0; c < 16; c++)
          for (int r = 0; r < 16; r++)
            for (int wpc = 0; wpc < 2; wpc++)
              for (int wb = 0; wb < 2; wb++) begin
                bit pad, flt, fexp;
                string rq;
                set_flag(f0[0]);
                pad  = (c >= 1 && c <= 3);
                flt  = f0[0] && en[0] && !pad;
                fexp = flt ? 1'b1 : exp_sets(c, r, wpc[0], wb[0]);
                rq   = en[0] ? req_of(c) : {"R10/", req_of(c)};
                cyc(en[0], 1'b0, 1'b1, c, r, wpc[0], wb[0], flt, 1'b1, rq);
                chk({rq, " flag"}, flag_o, fexp);
              end

    // Idle cycles hold the flag in both states
    for (int f0 = 0; f0 < 2; f0++) begin
      set_flag(f0[0]);
      for (int k = 0; k < 3; k++) begin
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        chk("R11 flag hold", flag_o, f0);
      end
    end

    // Clear has priority over a setting retirement
    set_flag(1'b0);
    cyc(1'b1, 1'b1, 1'b1, 4, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    chk("R9 clear vs set", flag_o, 0);
    // Clear alongside a faulting retirement: fault still pulses, flag cleared
    set_flag(1'b1);
    cyc(1'b1, 1'b1, 1'b1, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    chk("R9 clear vs fault", flag_o, 0);
    // Clear alone with the flag set
    set_flag(1'b1);
    cyc(1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    chk("R9 clear idle", flag_o, 0);

    // Repeated faults while the flag stays set
    set_flag(1'b1);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 1'b0, 1'b1, 13, 0, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
      chk("R3 flag kept", flag_o, 1);
    end
    cyc(1'b1, 1'b0, 1'b1, 2, 0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    chk("R2 pad after faults", flag_o, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule